// File: doc/BRIEF.md
# ADC Sample and Conversion Sequencer

This block is the digital control state machine of a serially controlled, multi-channel analog-to-digital converter. For every chip-select cycle it decides whether the cycle samples the selected input and then converts it, or only reads out the result already held. A second, asynchronous start line lets the host run extended sampling. The start line's low time sets the acquisition window, and the start line's rising edge puts the sample on hold and schedules the conversion.

A pending-output flag links the two paths. The rising edge of the start line sets it, and every rising edge of chip select clears it. When chip select falls, the flag is tested. If it is clear, the cycle samples for a fixed number of I/O clock rising edges and then converts. If it is set, the cycle only outputs the result and loads the next channel address. All control inputs are brought into the system clock domain through two-flop synchronisers before edge detection. A counter of fixed length stands in for the converter core.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, sample_en, busy, conv_start, result_valid and result_discard are all 0, and sample_ch is 0.
- R2: A falling edge on start_n while cs_n is high and the block is idle begins extended sampling. sample_en rises at the third clk rising edge after the input change and stays high for as long as start_n stays low.
- R3: A rising edge on start_n during extended sampling drops sample_en at the third clk rising edge after the input change. conv_start then pulses high for exactly one cycle, two clk edges later. Ending normal sampling follows the same hold-then-convert timing.
- R4: busy is high for exactly CONV_CYCLES clk cycles, starting in the cycle where conv_start is high. result_valid becomes 1 on the edge where busy falls.
- R5: When a start_n fall is accepted while result_valid is 1, result_discard pulses for one cycle and result_valid clears on the same edge.
- R6: A rising edge of start_n sets the pending-output flag. A cs_n fall that finds the flag set runs an output-only cycle, with no sampling, no conv_start and no busy.
- R7: Every cs_n rising edge clears the pending-output flag. A cs_n fall that finds the flag clear, with the block idle, raises sample_en. sample_en then holds for exactly NORM_EDGES (default 6) rising edges of io_clk, and the R3 hold and conversion follow.
- R8: A falling edge on start_n while cs_n is low is ignored. sample_en, result_valid and result_discard do not change, and the pending-output flag stays clear.
- R9: Every cs_n fall latches mux_addr as the channel for the next sampling period. That period may be normal or extended. sample_ch shows the channel being sampled and stays stable while sample_en is high.
- R10: result_valid is cleared by every falling edge of cs_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| io_clk | input | 1 | Serial I/O clock, asynchronous |
| start_n | input | 1 | Extended-sampling start line, active low, asynchronous |
| mux_addr | input | AW | Channel address loaded at each chip-select fall |
| sample_en | output | 1 | 1 = track the input, 0 = hold |
| sample_ch | output | AW | Channel being sampled |
| conv_start | output | 1 | One-cycle pulse when conversion begins |
| busy | output | 1 | Conversion in progress |
| result_valid | output | 1 | A converted result is waiting to be read |
| result_discard | output | 1 | One-cycle pulse when a waiting result is dropped |

## Verification
The bench runs four kinds of chip-select and start-line activity in sequence, so that the pending-output flag passes through all of its states. First comes a normal cycle that starts from the reset flag value. Next is an extended sample over a waiting result, which separates discard-and-resample from plain sampling. An output-only cycle follows. It shows that a set flag suppresses sampling, and that the address latched there is the one the following normal cycle samples. The last pattern pulses start_n while chip select is low. It must leave both the outputs and the flag untouched, and a later chip-select cycle shows this by sampling normally.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_NSAMP  = 3'd1,
        ST_XSAMP  = 3'd2,
        ST_SETTLE = 3'd3,
        ST_CONV   = 3'd4
    } seq_state_e;

    // bit positions of the synchronised control lines
    localparam int unsigned LN_CS    = 0;
    localparam int unsigned LN_START = 1;
    localparam int unsigned LN_IO    = 2;
    localparam int unsigned LN_COUNT = 3;

endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
    parameter int unsigned       W       = 3,
    parameter logic [W-1:0]      RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] prev_o
);

    for (genvar g = 0; g < W; g++) begin : g_line
        logic meta_q, lvl_q, prev_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[g];
                lvl_q  <= RST_VAL[g];
                prev_q <= RST_VAL[g];
            end else begin
                meta_q <= async_i[g];
                lvl_q  <= meta_q;
                prev_q <= lvl_q;
            end
        end

        assign lvl_o[g]  = lvl_q;
        assign prev_o[g] = prev_q;
    end

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int unsigned AW          = 3,
    parameter int unsigned CONV_CYCLES = 10,
    parameter int unsigned NORM_EDGES  = 6,
    parameter int unsigned SETTLE_CYC  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [LN_COUNT-1:0] lvl,
    input  logic [LN_COUNT-1:0] prev,
    input  logic [AW-1:0]       mux_addr,
    output logic                sample_en,
    output logic [AW-1:0]       sample_ch,
    output logic                conv_start,
    output logic                busy,
    output logic                result_valid,
    output logic                result_discard
);

    localparam int unsigned MAXC = (CONV_CYCLES > NORM_EDGES)
                                 ? ((CONV_CYCLES > SETTLE_CYC) ? CONV_CYCLES : SETTLE_CYC)
                                 : ((NORM_EDGES > SETTLE_CYC) ? NORM_EDGES : SETTLE_CYC);
    localparam int unsigned CW = $clog2(MAXC + 1);
    localparam logic [CW-1:0] CONV_LAST   = CW'(CONV_CYCLES - 1);
    localparam logic [CW-1:0] NORM_LAST   = CW'(NORM_EDGES - 1);
    localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CYC - 1);

    typedef struct packed {
        seq_state_e    st;
        logic [CW-1:0] cnt;
        logic          pend;
        logic [AW-1:0] ch;
        logic [AW-1:0] samp_ch;
        logic          valid;
        logic          conv;
        logic          disc;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic cs_fall, cs_rise, cs_high, st_fall, st_rise, io_rise;

    always_comb begin
        cs_high = lvl[LN_CS];
        cs_fall = prev[LN_CS] & ~lvl[LN_CS];
        cs_rise = ~prev[LN_CS] & lvl[LN_CS];
        st_fall = prev[LN_START] & ~lvl[LN_START];
        st_rise = ~prev[LN_START] & lvl[LN_START];
        io_rise = ~prev[LN_IO] & lvl[LN_IO];
    end

    always_comb begin
        r_d      = r_q;
        r_d.conv = 1'b0;
        r_d.disc = 1'b0;

        if (cs_rise) begin
            r_d.pend = 1'b0;
        end
        if (cs_fall) begin
            r_d.ch    = mux_addr;
            r_d.valid = 1'b0;
        end

        unique case (r_q.st)
            ST_IDLE: begin
                if (cs_fall && !r_q.pend) begin
                    r_d.st      = ST_NSAMP;
                    r_d.cnt     = '0;
                    r_d.samp_ch = r_q.ch;
                end else if (st_fall && cs_high) begin
                    r_d.st      = ST_XSAMP;
                    r_d.samp_ch = r_q.ch;
                    r_d.disc    = r_q.valid;
                    r_d.valid   = 1'b0;
                end
            end
            ST_NSAMP: begin
                if (cs_rise) begin
                    r_d.st = ST_IDLE;
                end else if (io_rise) begin
                    if (r_q.cnt == NORM_LAST) begin
                        r_d.st  = ST_SETTLE;
                        r_d.cnt = '0;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
            ST_XSAMP: begin
                if (st_rise) begin
                    r_d.st   = ST_SETTLE;
                    r_d.cnt  = '0;
                    r_d.pend = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (r_q.cnt == SETTLE_LAST) begin
                    r_d.st   = ST_CONV;
                    r_d.cnt  = '0;
                    r_d.conv = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_CONV: begin
                if (r_q.cnt == CONV_LAST) begin
                    r_d.st    = ST_IDLE;
                    r_d.cnt   = '0;
                    r_d.valid = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign sample_en      = (r_q.st == ST_NSAMP) || (r_q.st == ST_XSAMP);
    assign busy           = (r_q.st == ST_CONV);
    assign sample_ch      = r_q.samp_ch;
    assign conv_start     = r_q.conv;
    assign result_valid   = r_q.valid;
    assign result_discard = r_q.disc;

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int unsigned AW          = 3,
    parameter int unsigned CONV_CYCLES = 10,
    parameter int unsigned NORM_EDGES  = 6,
    parameter int unsigned SETTLE_CYC  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          io_clk,
    input  logic          start_n,
    input  logic [AW-1:0] mux_addr,
    output logic          sample_en,
    output logic [AW-1:0] sample_ch,
    output logic          conv_start,
    output logic          busy,
    output logic          result_valid,
    output logic          result_discard
);

    localparam logic [LN_COUNT-1:0] IDLE_LVL = LN_COUNT'((1 << LN_CS) | (1 << LN_START));

    logic [LN_COUNT-1:0] raw, lvl, prev;

    always_comb begin
        raw           = '0;
        raw[LN_CS]    = cs_n;
        raw[LN_START] = start_n;
        raw[LN_IO]    = io_clk;
    end

    adc_seq_sync #(
        .W       (LN_COUNT),
        .RST_VAL (IDLE_LVL)
    ) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw),
        .lvl_o   (lvl),
        .prev_o  (prev)
    );

    adc_seq_fsm #(
        .AW          (AW),
        .CONV_CYCLES (CONV_CYCLES),
        .NORM_EDGES  (NORM_EDGES),
        .SETTLE_CYC  (SETTLE_CYC)
    ) i_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .lvl            (lvl),
        .prev           (prev),
        .mux_addr       (mux_addr),
        .sample_en      (sample_en),
        .sample_ch      (sample_ch),
        .conv_start     (conv_start),
        .busy           (busy),
        .result_valid   (result_valid),
        .result_discard (result_discard)
    );

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
    parameter int unsigned AW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sample_en,
    input logic [AW-1:0] sample_ch,
    input logic          conv_start,
    input logic          busy,
    input logic          result_valid,
    input logic          result_discard
);

    AST_BUSY_NO_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sample_en);                                            // R4

    AST_CONV_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);                                     // R3

    AST_SETTLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> busy && $past(!sample_en) && $past(!busy));       // R3

    AST_VALID_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(result_valid) |-> $fell(busy));                            // R4

    AST_DISCARD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        result_discard |-> !result_valid && sample_en);                  // R5

    AST_CH_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && $past(sample_en)) |-> $stable(sample_ch));         // R9

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.AW(AW)) i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .sample_en      (sample_en),
    .sample_ch      (sample_ch),
    .conv_start     (conv_start),
    .busy           (busy),
    .result_valid   (result_valid),
    .result_discard (result_discard)
);

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;

    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned AW         = 3;
    localparam int unsigned CONV_CYC   = 10;
    localparam int unsigned NORM       = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic          io_clk = 1'b0;
    logic          start_n = 1'b1;
    logic [AW-1:0] mux_addr = '0;
    logic          sample_en, conv_start, busy, result_valid, result_discard;
    logic [AW-1:0] sample_ch;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    adc_seq_ctrl #(
        .AW          (AW),
        .CONV_CYCLES (CONV_CYC),
        .NORM_EDGES  (NORM)
    ) i_adc_seq_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .cs_n           (cs_n),
        .io_clk         (io_clk),
        .start_n        (start_n),
        .mux_addr       (mux_addr),
        .sample_en      (sample_en),
        .sample_ch      (sample_ch),
        .conv_start     (conv_start),
        .busy           (busy),
        .result_valid   (result_valid),
        .result_discard (result_discard)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic io_pulse();
        io_clk = 1'b1; tick(4);
        io_clk = 1'b0; tick(4);
    endtask

    // hold edge already driven: check hold, conversion start and completion
    task automatic hold_and_convert(input string tag);
        tick(3);
        chk({tag, " R3 sample_en low after hold"}, sample_en, 0);
        chk({tag, " R3 no conv yet"}, conv_start, 0);
        tick(2);
        chk({tag, " R3 conv_start pulse"}, conv_start, 1);
        chk({tag, " R4 busy with conv_start"}, busy, 1);
        tick(1);
        chk({tag, " R3 conv_start one cycle"}, conv_start, 0);
        tick(CONV_CYC - 2);
        chk({tag, " R4 busy last cycle"}, busy, 1);
        chk({tag, " R4 valid not yet"}, result_valid, 0);
        tick(1);
        chk({tag, " R4 busy ends"}, busy, 0);
        chk({tag, " R4 valid set"}, result_valid, 1);
    endtask

    task automatic t_reset();
        tick(3);
        chk("R1 sample_en", sample_en, 0);
        chk("R1 busy", busy, 0);
        chk("R1 conv_start", conv_start, 0);
        chk("R1 result_valid", result_valid, 0);
        chk("R1 result_discard", result_discard, 0);
        chk("R1 sample_ch", sample_ch, 0);
    endtask

    task automatic t_normal(input logic [AW-1:0] addr, input int exp_ch, input string tag);
        mux_addr = addr;
        cs_n = 1'b0;
        tick(2);
        chk({tag, " R7 not yet sampling"}, sample_en, 0);
        tick(1);
        chk({tag, " R7 sampling on cs fall"}, sample_en, 1);
        chk({tag, " R9 channel"}, sample_ch, exp_ch);
        chk({tag, " R10 valid cleared"}, result_valid, 0);
        for (int i = 0; i < NORM - 1; i++) io_pulse();
        chk({tag, " R7 still sampling before last edge"}, sample_en, 1);
        io_clk = 1'b1;
        hold_and_convert(tag);
        io_clk = 1'b0;
        tick(2);
    endtask

    task automatic t_extended(input int exp_ch);
        cs_n = 1'b1;
        tick(4);
        chk("R5 valid waiting before start", result_valid, 1);
        start_n = 1'b0;
        tick(3);
        chk("R2 extended sampling begins", sample_en, 1);
        chk("R2 R9 preset channel", sample_ch, exp_ch);
        chk("R5 discard pulse", result_discard, 1);
        chk("R5 valid dropped", result_valid, 0);
        tick(1);
        chk("R5 discard one cycle", result_discard, 0);
        tick(20);
        chk("R2 sampling held while low", sample_en, 1);
        start_n = 1'b1;
        hold_and_convert("ext");
    endtask

    task automatic t_read_only(input logic [AW-1:0] addr);
        mux_addr = addr;
        cs_n = 1'b0;
        tick(3);
        chk("R6 no sampling in output cycle", sample_en, 0);
        chk("R10 valid cleared by cs fall", result_valid, 0);
        for (int i = 0; i < NORM; i++) io_pulse();
        chk("R6 still no sampling", sample_en, 0);
        chk("R6 no conversion", busy, 0);
        chk("R6 no conv pulse", conv_start, 0);
        cs_n = 1'b1;
        tick(4);
    endtask

    task automatic t_start_while_cs_low();
        // block idle, cs low, valid result waiting
        chk("R8 valid waiting", result_valid, 1);
        start_n = 1'b0;
        tick(3);
        chk("R8 no sampling", sample_en, 0);
        chk("R8 no discard", result_discard, 0);
        chk("R8 valid kept", result_valid, 1);
        tick(5);
        start_n = 1'b1;
        tick(5);
        chk("R8 no conversion", busy, 0);
        cs_n = 1'b1;
        tick(4);
        // flag must be clear: next cycle samples normally
        cs_n = 1'b0;
        tick(3);
        chk("R8 R7 normal cycle follows", sample_en, 1);
        chk("R9 channel from previous cycle", sample_ch, 7);
        cs_n = 1'b1;
        tick(4);
        chk("R7 cs rise aborts sampling", sample_en, 0);
    endtask

    initial begin
        tick(4);
        rst_n = 1'b1;
        t_reset();
        t_normal(3'd5, 0, "norm1");
        t_extended(5);
        t_read_only(3'd2);
        t_normal(3'd7, 2, "norm2");
        t_start_while_cs_low();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule